// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is an 8-bit accumulator attached to a single input pin. It has two modes. In edge-counting mode, the count goes up by one on every active transition of the pin. In gated-duration mode, the count goes up once per divide-by-64 tick of the bus clock, and only while the pin sits at its active level. In that mode the count measures how long the pin stayed active, in units of 64 clocks. A single polarity input chooses which edge or level counts as active.

The pin passes through a two-flop synchroniser before any logic sees it. The prescaler runs all the time, whatever the mode. Software can preload the count at any time. Two sticky flags record events: count wrap, and pin activity. Writing a one to a flag clears it. A registered interrupt output combines each flag with its own enable.

Top module: `pulse_accum`

## Requirements
- R1: After synchronous reset, the count is 0x00, both flags are 0 and `irq_o` is 0.
- R2: With `cfg_gated`=0 and `cfg_pol`=0, each rising transition of `pin_i` adds one to the count. Falling transitions add nothing.
- R3: With `cfg_gated`=0 and `cfg_pol`=1, each falling transition of `pin_i` adds one to the count. Rising transitions add nothing.
- R4: With `cfg_gated`=1, the active level is high when `cfg_pol`=0 and low when `cfg_pol`=1. If the pin is held active for exactly 64*N consecutive clocks, the count rises by exactly N. While the pin is inactive, the count does not change.
- R5: `pin_flag_o` sets on every counted transition in edge-counting mode. In gated mode it sets only when the pin leaves its active level, never when the pin enters it.
- R6: `wrap_flag_o` sets when an increment takes the count from 0xFF to 0x00.
- R7: On a clock with `flag_clr` bit 0 high, the wrap flag clears. On a clock with `flag_clr` bit 1 high, the pin flag clears. A zero bit leaves its flag unchanged.
- R8: If a flag's set event and its clear bit fall in the same clock, the flag ends up set.
- R9: `cnt_wr` loads `cnt_wdata` into the count on the next edge. The load overrides an increment that falls in the same clock, and that dropped increment does not set the wrap flag.
- R10: While `cfg_en` is 0, the pin neither changes the count nor sets the pin flag.
- R11: `irq_o` is high exactly when (wrap flag and `cfg_wrap_ie`) or (pin flag and `cfg_pin_ie`). It changes on the same edge as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous accumulator input pin |
| cfg_en | input | 1 | Accumulator enable |
| cfg_gated | input | 1 | 0 = edge counting, 1 = gated duration |
| cfg_pol | input | 1 | 0 = rising edge / high level active, 1 = falling edge / low level active |
| cfg_wrap_ie | input | 1 | Interrupt enable for the wrap flag |
| cfg_pin_ie | input | 1 | Interrupt enable for the pin flag |
| cnt_wr | input | 1 | Count load strobe |
| cnt_wdata | input | 8 | Value to load into the count |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 wrap flag, bit 1 pin flag |
| count_o | output | 8 | Current count |
| wrap_flag_o | output | 1 | Sticky wrap flag |
| pin_flag_o | output | 1 | Sticky pin-activity flag |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two collisions are tested.

The first is a software flag clear landing in the same clock as a hardware flag set. The bench raises the pin and counts two clock edges of synchroniser delay. It then pulses `flag_clr` bit 1 so that the clear lands on the same edge as the counted transition. The test passes only if the pin flag reads back as 1.

The second is a count load landing on the same edge as an increment from 0xFF. The bench expects the loaded value to appear and the wrap flag to stay clear.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int FLAG_N    = 2;
  localparam int FLAG_WRAP = 0;
  localparam int FLAG_PIN  = 1;

  typedef struct packed {
    logic en;
    logic gated;
    logic pol;
    logic wrap_ie;
    logic pin_ie;
  } pa_cfg_t;
endpackage

// File: rtl/pa_pin_sync.sv
module pa_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic pol_i,
  output logic lvl_o,
  output logic act_edge_o,
  output logic trail_edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              prev_lvl;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  // The polarity is applied to both samples, so changing it never fakes an edge.
  assign lvl_o        = sync_q[STAGES-1] ^ pol_i;
  assign prev_lvl     = prev_q ^ pol_i;
  assign act_edge_o   = lvl_o & ~prev_lvl;
  assign trail_edge_o = ~lvl_o & prev_lvl;

  // Edge detection needs the previous sample to catch up, so active edges never repeat back to back.
  assert_edge_single_R2: assert property (@(posedge clk) disable iff (rst)
    (act_edge_o && $stable(pol_i)) |=> !act_edge_o)
    else $error("active edge reported on two consecutive clocks");
endmodule

// File: rtl/pa_prescaler.sv
module pa_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst)                pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  assign tick_o = (pre_q == LAST);

  // One tick per DIV clocks (R4): two ticks never come back to back.
  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o)
    else $error("prescaler ticked on consecutive clocks");
endmodule

// File: rtl/pa_core.sv
module pa_core
  import pa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pa_cfg_t           cfg,
  input  logic              tick,
  input  logic              lvl,
  input  logic              act_edge,
  input  logic              trail_edge,
  input  logic              cnt_wr,
  input  logic [W-1:0]      cnt_wdata,
  input  logic [FLAG_N-1:0] flag_clr,
  output logic [W-1:0]      count_q,
  output logic              wrap_q,
  output logic              pin_q,
  output logic              irq_q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] TOP = '1;

  logic         inc, ev, wrap_ev;
  logic [W-1:0] cnt_n;
  logic         wrap_n, pin_n, irq_n;

  always_comb begin
    inc     = cfg.en & (cfg.gated ? (tick & lvl) : act_edge);
    ev      = cfg.en & (cfg.gated ? trail_edge : act_edge);
    wrap_ev = inc & ~cnt_wr & (count_q == TOP);
    if (cnt_wr)   cnt_n = cnt_wdata;
    else if (inc) cnt_n = count_q + ONE;
    else          cnt_n = count_q;
    wrap_n = wrap_ev | (wrap_q & ~flag_clr[FLAG_WRAP]);
    pin_n  = ev      | (pin_q  & ~flag_clr[FLAG_PIN]);
    irq_n  = (wrap_n & cfg.wrap_ie) | (pin_n & cfg.pin_ie);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      wrap_q  <= 1'b0;
      pin_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      count_q <= cnt_n;
      wrap_q  <= wrap_n;
      pin_q   <= pin_n;
      irq_q   <= irq_n;
    end
  end

  assert_load_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (count_q == $past(cnt_wdata)))
    else $error("count load not taken");

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> ((count_q == $past(count_q)) || (count_q == ($past(count_q) + ONE))))
    else $error("count moved by more than one");

  assert_hold_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    (!cfg.en && !cnt_wr) |=> (count_q == $past(count_q)))
    else $error("count changed while disabled");

  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wrap_q) |-> (count_q == '0))
    else $error("wrap flag set without wrap to zero");

  assert_irq_source_R11: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (wrap_q || pin_q))
    else $error("interrupt without a flag");
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pa_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_DIV     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_i,
  input  logic             cfg_en,
  input  logic             cfg_gated,
  input  logic             cfg_pol,
  input  logic             cfg_wrap_ie,
  input  logic             cfg_pin_ie,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [1:0]       flag_clr,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_flag_o,
  output logic             pin_flag_o,
  output logic             irq_o
);
  pa_cfg_t cfg;
  logic    tick, lvl, act_edge, trail_edge;

  assign cfg = '{en: cfg_en, gated: cfg_gated, pol: cfg_pol,
                 wrap_ie: cfg_wrap_ie, pin_ie: cfg_pin_ie};

  pa_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pin_i), .pol_i(cfg_pol),
    .lvl_o(lvl), .act_edge_o(act_edge), .trail_edge_o(trail_edge)
  );

  pa_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  pa_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .cfg(cfg), .tick(tick), .lvl(lvl),
    .act_edge(act_edge), .trail_edge(trail_edge),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .flag_clr(flag_clr),
    .count_q(count_o), .wrap_q(wrap_flag_o), .pin_q(pin_flag_o), .irq_q(irq_o)
  );
endmodule

// File: tb/sim_pulse_accum.sv
module sim_pulse_accum;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_i = 1'b0;
  logic       cfg_en = 1'b1, cfg_gated = 1'b0, cfg_pol = 1'b0;
  logic       cfg_wrap_ie = 1'b0, cfg_pin_ie = 1'b0;
  logic       cnt_wr = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic [1:0] flag_clr = '0;
  logic [7:0] count_o;
  logic       wrap_flag_o, pin_flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pulse_accum u0 (
    .clk(clk), .rst(rst), .pin_i(pin_i), .cfg_en(cfg_en), .cfg_gated(cfg_gated),
    .cfg_pol(cfg_pol), .cfg_wrap_ie(cfg_wrap_ie), .cfg_pin_ie(cfg_pin_ie),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .flag_clr(flag_clr),
    .count_o(count_o), .wrap_flag_o(wrap_flag_o), .pin_flag_o(pin_flag_o), .irq_o(irq_o)
  );

  // {pol, pulses[3:0], preload[7:0], expected count[7:0], expected wrap}
  localparam logic [21:0] VEC [5] = '{
    {1'b0, 4'd5, 8'h00, 8'h05, 1'b0},
    {1'b1, 4'd3, 8'h0A, 8'h0D, 1'b0},
    {1'b0, 4'd4, 8'hFE, 8'h02, 1'b1},
    {1'b1, 4'd1, 8'hFF, 8'h00, 1'b1},
    {1'b0, 4'd0, 8'h07, 8'h07, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input logic gated, input logic pol);
    @(negedge clk);
    cfg_gated = gated;
    cfg_pol   = pol;
    pin_i     = pol;
    clocks(5);
  endtask

  task automatic load(input logic [7:0] v);
    cnt_wr = 1'b1; cnt_wdata = v;
    clocks(1);
    cnt_wr = 1'b0;
  endtask

  task automatic clear(input logic [1:0] m);
    flag_clr = m;
    clocks(1);
    flag_clr = 2'b00;
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      pin_i = ~cfg_pol; clocks(3);
      pin_i = cfg_pol;  clocks(3);
    end
    clocks(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clocks(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 wrap", wrap_flag_o, 0);
    chk("R1 pin", pin_flag_o, 0);
    chk("R1 irq", irq_o, 0);

    // Table walk: edge-counting mode, both polarities (R2, R3, R5, R6)
    for (int i = 0; i < 5; i++) begin
      logic [21:0] v;
      v = VEC[i];
      setup(1'b0, v[21]);
      load(v[16:9]);
      clear(2'b11);
      pulses(int'(v[20:17]));
      chk(v[21] ? "R3 count" : "R2 count", count_o, v[8:1]);
      chk("R6 wrap", wrap_flag_o, v[0]);
      chk("R5 pin flag", pin_flag_o, (v[20:17] != 0));
    end

    // R7 selective write-one-to-clear
    setup(1'b0, 1'b0); load(8'hFF); clear(2'b11); pulses(1);
    chk("R7 wrap before", wrap_flag_o, 1);
    clear(2'b10);
    chk("R7 pin cleared", pin_flag_o, 0);
    chk("R7 wrap kept", wrap_flag_o, 1);
    clear(2'b01);
    chk("R7 wrap cleared", wrap_flag_o, 0);

    // R8 set and clear on the same edge: set wins
    setup(1'b0, 1'b0); load(8'h00); clear(2'b11);
    pin_i = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    flag_clr = 2'b10;
    @(posedge clk); @(negedge clk);
    flag_clr = 2'b00;
    chk("R8 pin flag", pin_flag_o, 1);
    chk("R8 count", count_o, 1);
    pin_i = 1'b0; clocks(3);

    // R9 load collides with increment from 0xFF
    setup(1'b0, 1'b0); load(8'hFF); clear(2'b11);
    pin_i = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    cnt_wr = 1'b1; cnt_wdata = 8'h40;
    @(posedge clk); @(negedge clk);
    cnt_wr = 1'b0;
    chk("R9 count", count_o, 8'h40);
    chk("R9 no wrap", wrap_flag_o, 0);
    pin_i = 1'b0; clocks(3);

    // R10 disabled: pin ignored
    cfg_en = 1'b0;
    setup(1'b0, 1'b0); load(8'h03); clear(2'b11);
    pulses(3);
    chk("R10 count", count_o, 3);
    chk("R10 pin flag", pin_flag_o, 0);
    cfg_en = 1'b1;

    // R4/R5 gated, high active, 128 clocks -> +2
    setup(1'b1, 1'b0); load(8'h00); clear(2'b11);
    pin_i = 1'b1; clocks(10);
    chk("R5 no flag on leading", pin_flag_o, 0);
    clocks(118);
    pin_i = 1'b0; clocks(5);
    chk("R4 gated high", count_o, 2);
    chk("R5 trailing flag", pin_flag_o, 1);
    clocks(200);
    chk("R4 inactive hold", count_o, 2);

    // R4 gated, low active, 192 clocks -> +3
    setup(1'b1, 1'b1); load(8'h10); clear(2'b11);
    pin_i = 1'b0; clocks(192);
    pin_i = 1'b1; clocks(5);
    chk("R4 gated low", count_o, 8'h13);

    // R11 interrupt follows enabled flags
    setup(1'b0, 1'b0); load(8'hFF); clear(2'b11);
    cfg_wrap_ie = 1'b1;
    pulses(1);
    chk("R11 irq set", irq_o, 1);
    clear(2'b01);
    chk("R11 irq cleared", irq_o, 0);
    cfg_wrap_ie = 1'b0;
    load(8'hFF); pulses(1);
    chk("R11 flag without enable", wrap_flag_o, 1);
    chk("R11 irq masked", irq_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule